// File: doc/BRIEF.md
# Infrared Mark and Symbol Capture

This block times a demodulated remote-control input, either infrared or UHF. A programmable divider turns the system clock into a sample tick. The input pin passes through a two-flop synchronizer and an optional inversion. On each symbol the block counts two values in ticks: the time the input is active (the mark), and the time from the start of that mark to the start of the next valid mark (the period). Space is the period minus the mark.

Each mark/period pair is written into an eight-entry FIFO, and software reads it through a 32-bit register bus. A symbol is written once the next valid mark has finished. If no valid mark starts within a programmable maximum period, the symbol is written at once with a period of all ones, which tells software that the pulse train has ended. Marks shorter than a programmable noise count are thrown away.

The register bus is plain: a request is taken in every cycle it is presented, and read data is combinational in that same cycle. Pops happen at the clock edge that ends the read cycle. There is no valid/ready back-pressure, because the FIFO drains only through register reads. When the FIFO is full, a new symbol is dropped and flagged instead of stalling the capture.

Top module: `ir_symbol_rx`

## Requirements
- R1: The sample tick fires once every D system clocks, where D is the value in register 0x30 (bits 15:0). A D of 0 or 1 means a tick every clock. Every count is in ticks.
- R2: An entry holds mark = the number of consecutive active ticks, and period = the number of ticks from this mark's first active tick to the first active tick of the next valid mark.
- R3: A symbol ends its train when no valid mark starts within the maximum period (register 0x14, bits 15:0) counted from its mark start. It is then pushed with period 0xFFFF, and interrupt status bit 1 (last symbol) is set.
- R4: A mark shorter than the noise count (register 0x1C, bits 15:0) makes no entry. Its ticks count as space inside the enclosing period.
- R5: When bit 0 of register 0x28 is 1, a low pin is the active level. When it is 0, a high pin is active.
- R6: Reading 0x00 returns the mark at the FIFO head in bits 15:0 and does not pop. Reading 0x04 returns the head period in bits 15:0 and pops that entry. On an empty FIFO both reads return 0 and nothing is popped.
- R7: The FIFO holds 8 entries. A symbol that arrives while the FIFO is full is dropped, the stored entries stay as they were, and overrun (interrupt status bit 2) is set.
- R8: Interrupt status (0x0C) has four bits: bit 0 is FIFO not empty, bit 1 is last symbol, bit 2 is overrun, and bit 3 is FIFO full. The output irq is the OR of the status bits that are enabled in register 0x08, bits 3:0.
- R9: Writing a mask to 0x18 clears the sticky status bits 1 and 2 that are set in the mask. Bits 0 and 3 always follow the FIFO.
- R10: Receive status (0x2C) reports the number of FIFO entries in bits 15:8 and the overrun flag in bit 2. All other bits read 0.
- R11: When bit 0 of register 0x10 is 0, capture is off. No entry is pushed and any symbol in progress is abandoned.
- R12: After reset, the interrupt enable, receive enable, status and irq are all 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Demodulated remote-control input |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks a table of symbols with different mark/space ratios. It then checks the period arithmetic, because a design that measured from mark end, or counted space only, would report periods short by the mark length. A one-tick glitch in the middle of a space must vanish while its ticks still count toward the period. A filter that restarted the period would instead split the symbol in two. Flooding the FIFO past eight entries must leave the oldest entries intact and raise overrun. A design that overwrote entries or wrapped the pointers would return the wrong first entry. The bench also checks the divider against a known mark length, the inverted polarity, an empty pop, and a disabled capture.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int CW = 16;
  localparam logic [CW-1:0] PER_LAST = '1;

  typedef struct packed {
    logic [CW-1:0] mark;
    logic [CW-1:0] per;
  } sym_t;

  localparam logic [5:0] A_MARK  = 6'h00;
  localparam logic [5:0] A_PER   = 6'h04;
  localparam logic [5:0] A_IEN   = 6'h08;
  localparam logic [5:0] A_IST   = 6'h0C;
  localparam logic [5:0] A_RXEN  = 6'h10;
  localparam logic [5:0] A_MAXP  = 6'h14;
  localparam logic [5:0] A_ICLR  = 6'h18;
  localparam logic [5:0] A_NOISE = 6'h1C;
  localparam logic [5:0] A_INV   = 6'h28;
  localparam logic [5:0] A_STAT  = 6'h2C;
  localparam logic [5:0] A_DIV   = 6'h30;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  assign lim  = div - 1'b1;
  assign tick = (div <= W'(1)) || (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div > W'(1) && $past(div) == div && $past(tick)) |-> !tick);
endmodule

// File: rtl/ir_sym_meas.sv
module ir_sym_meas #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         pin,
  input  logic         inv,
  input  logic         tick,
  input  logic [W-1:0] noise,
  input  logic [W-1:0] max_per,
  output logic         push,
  output logic [W-1:0] push_mark,
  output logic [W-1:0] push_per
);
  localparam logic [W-1:0] SAT  = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] LAST = '1;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] x);
    return (x >= SAT) ? x : x + 1'b1;
  endfunction

  logic         s1, s2, act;
  logic         in_mark, pend;
  logic [W-1:0] cur, pend_mark, pend_per, start_per;
  logic         tmo;

  assign act = s2 ^ inv;
  assign tmo = pend && (pend_per >= max_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mark   <= 1'b0;
      pend      <= 1'b0;
      cur       <= '0;
      pend_mark <= '0;
      pend_per  <= '0;
      start_per <= '0;
      push      <= 1'b0;
      push_mark <= '0;
      push_per  <= '0;
    end else begin
      push <= 1'b0;
      if (!en) begin
        in_mark <= 1'b0;
        pend    <= 1'b0;
      end else if (tick) begin
        if (in_mark) begin
          if (act) begin
            cur <= sat_inc(cur);
            if (pend) pend_per <= sat_inc(pend_per);
          end else begin
            in_mark <= 1'b0;
            if (cur >= noise) begin
              if (pend) begin
                push      <= 1'b1;
                push_mark <= pend_mark;
                push_per  <= start_per;
              end
              pend      <= 1'b1;
              pend_mark <= cur;
              pend_per  <= sat_inc(cur);
            end else if (pend) begin
              pend_per <= sat_inc(pend_per);
            end
          end
        end else begin
          if (tmo) begin
            push      <= 1'b1;
            push_mark <= pend_mark;
            push_per  <= LAST;
            pend      <= 1'b0;
          end else if (pend) begin
            pend_per <= sat_inc(pend_per);
          end
          if (act) begin
            in_mark   <= 1'b1;
            cur       <= W'(1);
            start_per <= pend_per;
          end
        end
      end
    end
  end

  // R4
  noise_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_mark >= noise));

  // R3
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_per != LAST) |-> (push_per < max_per));

  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> !push);
endmodule

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == NW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R7
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
  import ir_rx_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter logic [15:0] RST_DIV    = 16'd1,
  parameter logic [15:0] RST_MAXPER = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_pin,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int NW = $clog2(DEPTH + 1);

  logic [3:0]    int_en;
  logic          rx_en, inv, last_q, ovr_q;
  logic [CW-1:0] max_per, noise, div;
  logic          tick, sym_push;
  logic [CW-1:0] sym_mark, sym_per;
  sym_t          head, wr_sym;
  logic [NW-1:0] count;
  logic          fifo_full, fifo_empty, pop, wr;
  logic [3:0]    int_st;

  assign wr     = bus_sel && bus_we;
  assign pop    = bus_sel && !bus_we && (bus_addr == A_PER);
  assign wr_sym = '{mark: sym_mark, per: sym_per};
  assign int_st = {fifo_full, ovr_q, last_q, !fifo_empty};
  assign irq    = |(int_st & int_en);

  ir_tick_gen #(.W(CW)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  ir_sym_meas #(.W(CW)) u_meas (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .pin(rx_pin), .inv(inv),
    .tick(tick), .noise(noise), .max_per(max_per), .push(sym_push),
    .push_mark(sym_mark), .push_per(sym_per)
  );

  ir_sym_fifo #(.DEPTH(DEPTH), .DW($bits(sym_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(sym_push), .din(wr_sym), .pop(pop),
    .dout(head), .count(count), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en  <= '0;
      rx_en   <= 1'b0;
      inv     <= 1'b0;
      max_per <= RST_MAXPER;
      noise   <= '0;
      div     <= RST_DIV;
      last_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (wr) begin
        unique case (bus_addr)
          A_IEN:   int_en  <= bus_wdata[3:0];
          A_RXEN:  rx_en   <= bus_wdata[0];
          A_MAXP:  max_per <= bus_wdata[CW-1:0];
          A_NOISE: noise   <= bus_wdata[CW-1:0];
          A_INV:   inv     <= bus_wdata[0];
          A_DIV:   div     <= bus_wdata[CW-1:0];
          A_ICLR: begin
            if (bus_wdata[1]) last_q <= 1'b0;
            if (bus_wdata[2]) ovr_q  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (sym_push && sym_per == PER_LAST) last_q <= 1'b1;
      if (sym_push && fifo_full)           ovr_q  <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        A_MARK:  bus_rdata = {16'b0, head.mark};
        A_PER:   bus_rdata = {16'b0, head.per};
        A_IEN:   bus_rdata = {28'b0, int_en};
        A_IST:   bus_rdata = {28'b0, int_st};
        A_RXEN:  bus_rdata = {31'b0, rx_en};
        A_MAXP:  bus_rdata = {16'b0, max_per};
        A_NOISE: bus_rdata = {16'b0, noise};
        A_INV:   bus_rdata = {31'b0, inv};
        A_STAT:  bus_rdata = {16'b0, 8'(count), 5'b0, ovr_q, 2'b0};
        A_DIV:   bus_rdata = {16'b0, div};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(sym_push && fifo_full));

  // R3
  last_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_q) |-> $past(sym_push && sym_per == PER_LAST));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);
endmodule

// File: tb/sim_ir_symbol_rx.sv
`timescale 1ns/1ps
module sim_ir_symbol_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pin = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic act_lvl = 1'b1;

  always #4 clk = ~clk;

  ir_symbol_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // mark, space, expected mark, expected period (space 0 = last symbol)
  localparam logic [63:0] VEC [0:4] = '{
    {16'd10, 16'd20, 16'd10, 16'd30},
    {16'd5,  16'd5,  16'd5,  16'd10},
    {16'd30, 16'd7,  16'd30, 16'd37},
    {16'd3,  16'd40, 16'd3,  16'd43},
    {16'd12, 16'd0,  16'd12, 16'hFFFF}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic sym(input int m, input int s);
    rx_pin = act_lvl;
    repeat (m) @(negedge clk);
    rx_pin = !act_lvl;
    repeat (s) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input logic [15:0] em, input logic [15:0] ep);
    logic [31:0] d;
    rd(6'h00, d); check(req, d, {16'b0, em});
    rd(6'h04, d); check(req, d, {16'b0, ep});
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(6'h0C, d); check("R12 int status", d, 0);
    rd(6'h2C, d); check("R12 rx status", d, 0);
    rd(6'h10, d); check("R12 rx enable", d, 0);
    check("R12 irq", {31'b0, irq}, 0);

    // R6 empty reads
    rd(6'h04, d); check("R6 empty period", d, 0);
    rd(6'h2C, d); check("R6 empty count", d, 0);

    wr(6'h14, 100);
    wr(6'h1C, 2);
    wr(6'h10, 1);

    // R2 R3 table walk
    for (int i = 0; i < 5; i++) sym(int'(VEC[i][63:48]), int'(VEC[i][47:32]));
    repeat (150) @(negedge clk);
    rd(6'h2C, d); check("R10 count 5", d, 32'h0500);
    rd(6'h0C, d); check("R8 status", d, 32'h3);
    wr(6'h08, 32'h2);
    #1 check("R8 irq on last", {31'b0, irq}, 1);
    wr(6'h18, 32'h2);
    #1 check("R9 irq after clear", {31'b0, irq}, 0);
    rd(6'h0C, d); check("R9 status", d, 32'h1);
    wr(6'h08, 32'h1);
    #1 check("R8 irq not empty", {31'b0, irq}, 1);
    for (int i = 0; i < 5; i++) pop_chk("R2 table", VEC[i][31:16], VEC[i][15:0]);
    #1 check("R8 irq drained", {31'b0, irq}, 0);
    wr(6'h08, 0);
    wr(6'h18, 32'h6);

    // R4 glitch inside space, and lone glitch
    sym(1, 20);
    sym(10, 5); sym(1, 10); sym(8, 0);
    repeat (150) @(negedge clk);
    rd(6'h2C, d); check("R4 count", d, 32'h0200);
    pop_chk("R4 glitch in space", 10, 26);
    pop_chk("R4 last", 8, 16'hFFFF);
    wr(6'h18, 32'h6);

    // R11 capture off
    wr(6'h10, 0);
    sym(10, 10); sym(10, 150);
    rd(6'h2C, d); check("R11 no entries", d, 0);
    rd(6'h0C, d); check("R11 no status", d, 0);

    // R5 inverted polarity
    rx_pin = 1'b1;
    wr(6'h28, 1);
    repeat (4) @(negedge clk);
    wr(6'h10, 1);
    act_lvl = 1'b0;
    sym(7, 150);
    pop_chk("R5 low active", 7, 16'hFFFF);
    wr(6'h10, 0);
    act_lvl = 1'b1;
    rx_pin = 1'b0;
    wr(6'h28, 0);
    repeat (4) @(negedge clk);
    wr(6'h18, 32'h6);

    // R1 divider
    wr(6'h30, 4);
    wr(6'h10, 1);
    sym(20, 500);
    pop_chk("R1 divided mark", 5, 16'hFFFF);
    wr(6'h10, 0);
    wr(6'h30, 1);
    wr(6'h18, 32'h6);

    // R7 overrun
    wr(6'h10, 1);
    for (int i = 0; i < 10; i++) sym(3, 3);
    repeat (150) @(negedge clk);
    rd(6'h0C, d); check("R7 status full ovr", d, 32'hF);
    rd(6'h2C, d); check("R10 count ovr", d, 32'h0804);
    wr(6'h18, 32'h6);
    rd(6'h0C, d); check("R9 clear sticky", d, 32'h9);
    for (int i = 0; i < 8; i++) pop_chk("R7 kept", 3, 6);
    rd(6'h2C, d); check("R6 drained", d, 0);
    rd(6'h04, d); check("R6 empty pop", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule